// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Micro-Operation Unit

This block applies one register-level micro-operation per clock to two operand words and stores the outcome in its own output register. A 4-bit function code picks one of fourteen operations. Four are arithmetic: sum, difference, plus-one and minus-one. Four are bitwise logic operations. Six are single-place shifts: logical, circular and arithmetic, each to the left or to the right. Along with the result the unit reports a carry-out and a flag that marks a sign change on an arithmetic left shift.

The surrounding datapath feeds the operand words and the function code, and loads the registered result into whichever destination it chooses. The difference is not formed by a separate subtractor. The one adder chain forms A plus the ones' complement of B plus one: a mode bit is XORed into every bit of B and also serves as the carry-in. Plus-one and minus-one use the same chain, with a constant in place of B.

Top module: `alsu_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, result, carry_out and shift_ovf are all cleared to zero at that edge.
- R2: Each output shows the operation chosen at a rising edge from that edge onward, so it is visible one clock after selection, and a new operation can be issued every cycle.
- R3: Function code 0 (add) gives result = A + B modulo 2^WIDTH, and carry_out is the carry out of the top bit.
- R4: Function code 1 (subtract) gives result = A + ~B + 1 = A - B modulo 2^WIDTH, and carry_out is 1 exactly when A >= B unsigned (no borrow).
- R5: Function code 2 (increment) gives A + 1, with carry_out 1 only when A is all ones. Function code 3 (decrement) gives A - 1, with carry_out 0 only when A is zero. B has no effect on either code.
- R6: Codes 4 to 7 are the logic group, selected by the two low code bits: 4 gives A AND B, 5 gives A OR B, 6 gives A XOR B, and 7 gives NOT A.
- R7: Code 8 shifts A left by one and code 9 shifts A right by one, with a 0 entering the vacated position in both cases.
- R8: Code 10 rotates A left by one and code 11 rotates A right by one, with the bit that leaves one end entering at the other end.
- R9: Code 12 (arithmetic left) shifts A left by one with a 0 entering. Code 13 (arithmetic right) keeps the sign bit and also copies it into the bit below.
- R10: shift_ovf is 1 only for code 12, and only when bits WIDTH-1 and WIDTH-2 of A differ. It is 0 for every other code.
- R11: carry_out is 0 for codes 4 to 15. The unused codes 14 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| func_sel | input | 4 | Operation code, see R3 to R11 |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (used by add, subtract and logic) |
| result | output | WIDTH | Registered operation result |
| carry_out | output | 1 | Registered adder carry for arithmetic codes, else 0 |
| shift_ovf | output | 1 | Registered sign-change flag for arithmetic left shift |

## Verification
Every output passes through one register, so each result, carry and flag is due at the first rising edge after the code and operands are applied, and stays there until the next edge. The bench changes inputs on falling edges and compares one full falling edge later, which lands in the middle of the cycle that holds the answer. The back-to-back test issues a new operation on each falling edge and checks the previous one in the same step, which confirms a one-cycle latency with no extra stage. The reset test lowers rst_n with a live operation applied and expects zeros one edge later.

// File: rtl/alsu_pkg.sv
// Package: shared function codes for the micro-operation unit.
// Assumes: 4-bit code; the two low bits of the logic group select the gate.
package alsu_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_INC  = 4'd2,
        FN_DEC  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_XOR  = 4'd6,
        FN_NOTA = 4'd7,
        FN_SHL  = 4'd8,
        FN_SHR  = 4'd9,
        FN_ROL  = 4'd10,
        FN_ROR  = 4'd11,
        FN_ASHL = 4'd12,
        FN_ASHR = 4'd13,
        FN_RSV0 = 4'd14,
        FN_RSV1 = 4'd15
    } alsu_func_e;

    localparam int unsigned FUNC_W = 4;

endpackage

// File: rtl/alsu_arith.sv
// Arithmetic stage: one ripple chain of full adders serves add, subtract,
// increment and decrement. The B word is replaced or inverted and a
// carry-in is chosen per operation.
// Assumes: op_code[1:0] holds 0=add, 1=sub, 2=inc, 3=dec.
module alsu_arith #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             cy_out
);

    logic [WIDTH-1:0] b_eff;
    logic             c_in;
    logic [WIDTH:0]   chain;

    // Choose the second addend and the carry-in for the requested operation.
    always_comb begin
        unique case (op_code)
            2'd0: begin b_eff = b_in;                    c_in = 1'b0; end
            2'd1: begin b_eff = b_in ^ {WIDTH{1'b1}};    c_in = 1'b1; end
            2'd2: begin b_eff = '0;                      c_in = 1'b1; end
            default: begin b_eff = {WIDTH{1'b1}};        c_in = 1'b0; end
        endcase
    end

    assign chain[0] = c_in;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fa
            assign sum_out[gi]  = a_in[gi] ^ b_eff[gi] ^ chain[gi];
            assign chain[gi+1]  = (a_in[gi] & b_eff[gi]) |
                                  (chain[gi] & (a_in[gi] ^ b_eff[gi]));
        end
    endgenerate

    assign cy_out = chain[WIDTH];

endmodule

// File: rtl/alsu_logic.sv
// Logic stage: per-bit AND, OR, XOR and complement of A, picked by a 2-bit code.
// Assumes: 0=AND, 1=OR, 2=XOR, 3=NOT A.
module alsu_logic #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [1:0]       gate_sel,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] bits_out
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            // One bit slice: four gates feeding a 4-to-1 selector.
            always_comb begin
                unique case (gate_sel)
                    2'd0:    bits_out[gi] = a_in[gi] & b_in[gi];
                    2'd1:    bits_out[gi] = a_in[gi] | b_in[gi];
                    2'd2:    bits_out[gi] = a_in[gi] ^ b_in[gi];
                    default: bits_out[gi] = ~a_in[gi];
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/alsu_shift.sv
// Shift stage: single-place logical, circular and arithmetic shifts of A.
// It also raises a sign-change flag for the arithmetic left shift.
// Assumes: WIDTH >= 2; shift_sel 0..5 = shl, shr, rol, ror, ashl, ashr.
module alsu_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [2:0]       shift_sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] shifted,
    output logic             sign_flip
);

    localparam int unsigned MSB = WIDTH - 1;

    // Form the shifted word for the selected kind of shift.
    always_comb begin
        unique case (shift_sel)
            3'd0, 3'd4: shifted = {a_in[MSB-1:0], 1'b0};
            3'd1:       shifted = {1'b0, a_in[MSB:1]};
            3'd2:       shifted = {a_in[MSB-1:0], a_in[MSB]};
            3'd3:       shifted = {a_in[0], a_in[MSB:1]};
            3'd5:       shifted = {a_in[MSB], a_in[MSB:1]};
            default:    shifted = '0;
        endcase
    end

    // Flag a sign change that an arithmetic left shift would cause.
    always_comb begin
        sign_flip = (shift_sel == 3'd4) && (a_in[MSB] != a_in[MSB-1]);
    end

endmodule

// File: rtl/alsu_unit.sv
// Top: decodes the function code, routes it to the arithmetic, logic and
// shift stages, and registers result, carry and shift-overflow flag.
// Assumes: synchronous active-low reset; one operation per clock.
module alsu_unit #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       func_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             shift_ovf
);

    import alsu_pkg::*;

    alsu_func_e       fn;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cy;
    logic [WIDTH-1:0] logic_bits;
    logic [WIDTH-1:0] shift_bits;
    logic             shift_flip;
    logic [2:0]       shift_sel;
    logic [WIDTH-1:0] next_res;
    logic             next_cy;
    logic             next_ovf;

    assign fn        = alsu_func_e'(func_sel);
    assign shift_sel = func_sel[3] ? {func_sel[2], func_sel[1:0]} : 3'd7;

    alsu_arith #(.WIDTH(WIDTH)) arith_i (
        .op_code (func_sel[1:0]),
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .sum_out (arith_sum),
        .cy_out  (arith_cy)
    );

    alsu_logic #(.WIDTH(WIDTH)) logic_i (
        .gate_sel (func_sel[1:0]),
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .bits_out (logic_bits)
    );

    alsu_shift #(.WIDTH(WIDTH)) shift_i (
        .shift_sel (shift_sel),
        .a_in      (opnd_a),
        .shifted   (shift_bits),
        .sign_flip (shift_flip)
    );

    // Pick the stage output that matches the function group.
    always_comb begin
        next_res = '0;
        next_cy  = 1'b0;
        next_ovf = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUB, FN_INC, FN_DEC: begin
                next_res = arith_sum;
                next_cy  = arith_cy;
            end
            FN_AND, FN_OR, FN_XOR, FN_NOTA: begin
                next_res = logic_bits;
            end
            FN_SHL, FN_SHR, FN_ROL, FN_ROR, FN_ASHL, FN_ASHR: begin
                next_res = shift_bits;
                next_ovf = shift_flip;
            end
            default: begin
                next_res = '0;
            end
        endcase
    end

    // Destination register: capture the selected outcome each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            shift_ovf <= 1'b0;
        end else begin
            result    <= next_res;
            carry_out <= next_cy;
            shift_ovf <= next_ovf;
        end
    end

endmodule

// File: rtl/alsu_unit_chk.sv
// Checker: temporal properties on the unit's ports, bound to every instance.
// Assumes: reset is driven low from time zero.
module alsu_unit_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       func_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             shift_ovf
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !carry_out && !shift_ovf));

    assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 4'd0) |=>
        ({carry_out, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 4'd1) |=> (carry_out == ($past(opnd_a) >= $past(opnd_b))));

    assert_rotate_keeps_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 4'd10 || func_sel == 4'd11) |=>
        ($countones(result) == $countones($past(opnd_a))));

    assert_ashr_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 4'd13) |=>
        (result[WIDTH-1] == $past(opnd_a[WIDTH-1]) &&
         result[WIDTH-2] == $past(opnd_a[WIDTH-1])));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel != 4'd12) |=> !shift_ovf);

    assert_no_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel[3] || func_sel[2]) |=> !carry_out);

endmodule

bind alsu_unit alsu_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_sel  (func_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .shift_ovf (shift_ovf)
);

// File: tb/alsu_unit_tb_top.sv
// Bench: walks a vector table of {code, A, B, result, carry, overflow},
// then runs directed reset and back-to-back checks.
module alsu_unit_tb_top;

    localparam int unsigned W    = 8;
    localparam int unsigned VW   = 4 + 3*W + 2;
    localparam int unsigned NVEC = 23;

    // {code, A, B, expected result, expected carry, expected overflow}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'd0,  8'h3C, 8'h05, 8'h41, 1'b0, 1'b0},
        {4'd0,  8'hF0, 8'h20, 8'h10, 1'b1, 1'b0},
        {4'd1,  8'h50, 8'h20, 8'h30, 1'b1, 1'b0},
        {4'd1,  8'h20, 8'h50, 8'hD0, 1'b0, 1'b0},
        {4'd1,  8'h37, 8'h37, 8'h00, 1'b1, 1'b0},
        {4'd2,  8'h06, 8'hAA, 8'h07, 1'b0, 1'b0},
        {4'd2,  8'hFF, 8'h13, 8'h00, 1'b1, 1'b0},
        {4'd3,  8'h00, 8'h55, 8'hFF, 1'b0, 1'b0},
        {4'd3,  8'h10, 8'hFF, 8'h0F, 1'b1, 1'b0},
        {4'd4,  8'hCA, 8'h6F, 8'h4A, 1'b0, 1'b0},
        {4'd5,  8'hCA, 8'h6F, 8'hEF, 1'b0, 1'b0},
        {4'd6,  8'hCA, 8'h6F, 8'hA5, 1'b0, 1'b0},
        {4'd7,  8'hCA, 8'h6F, 8'h35, 1'b0, 1'b0},
        {4'd8,  8'h81, 8'h00, 8'h02, 1'b0, 1'b0},
        {4'd9,  8'h81, 8'h00, 8'h40, 1'b0, 1'b0},
        {4'd10, 8'h81, 8'h00, 8'h03, 1'b0, 1'b0},
        {4'd11, 8'h81, 8'h00, 8'hC0, 1'b0, 1'b0},
        {4'd12, 8'h21, 8'h00, 8'h42, 1'b0, 1'b0},
        {4'd12, 8'h40, 8'h00, 8'h80, 1'b0, 1'b1},
        {4'd12, 8'hC3, 8'h00, 8'h86, 1'b0, 1'b0},
        {4'd13, 8'h84, 8'h00, 8'hC2, 1'b0, 1'b0},
        {4'd13, 8'h46, 8'h00, 8'h23, 1'b0, 1'b0},
        {4'd14, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   func_sel = 4'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         shift_ovf;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    alsu_unit #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_sel  (func_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .carry_out (carry_out),
        .shift_ovf (shift_ovf)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0:              return "R3";
            4'd1:              return "R4";
            4'd2, 4'd3:        return "R5";
            4'd4, 4'd5, 4'd6, 4'd7: return "R6";
            4'd8, 4'd9:        return "R7";
            4'd10, 4'd11:      return "R8";
            4'd12, 4'd13:      return "R9";
            default:           return "R11";
        endcase
    endfunction

    task automatic check_out(input string tag, input logic [W-1:0] er,
                             input logic ec, input logic ev);
        n_checks++;
        if (result !== er || carry_out !== ec || shift_ovf !== ev) begin
            n_errors++;
            $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                     tag, result, carry_out, shift_ovf, er, ec, ev);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        func_sel = c;
        opnd_a   = a;
        opnd_b   = b;
    endtask

    initial begin
        // R1: reset state after two edges with reset low
        @(negedge clk);
        apply(4'd0, 8'hFF, 8'hFF);
        @(negedge clk);
        check_out("R1 reset state", '0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table: R3..R11, each result due one edge later (R2)
        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            apply(v[VW-1 -: 4], v[VW-5 -: W], v[VW-5-W -: W]);
            @(negedge clk);
            check_out(req_of(v[VW-1 -: 4]), v[VW-5-2*W -: W], v[1], v[0]);
            if (v[VW-1 -: 4] == 4'd12)
                check_out("R10 overflow", v[VW-5-2*W -: W], v[1], v[0]);
        end

        // R2: back-to-back issue, each answer visible exactly one edge later
        apply(4'd0, 8'h01, 8'h01);
        @(negedge clk);
        apply(4'd6, 8'hF0, 8'h0F);
        check_out("R2 b2b add", 8'h02, 1'b0, 1'b0);
        @(negedge clk);
        apply(4'd12, 8'h7F, 8'h00);
        check_out("R2 b2b xor", 8'hFF, 1'b0, 1'b0);
        @(negedge clk);
        apply(4'd15, 8'h12, 8'h34);
        check_out("R10 b2b ashl flag", 8'hFE, 1'b0, 1'b1);
        @(negedge clk);
        check_out("R11 code 15", 8'h00, 1'b0, 1'b0);

        // R5: B has no effect on increment
        apply(4'd2, 8'h7F, 8'h00);
        @(negedge clk);
        check_out("R5 inc B=00", 8'h80, 1'b0, 1'b0);
        apply(4'd2, 8'h7F, 8'hFF);
        @(negedge clk);
        check_out("R5 inc B=FF", 8'h80, 1'b0, 1'b0);

        // R1: reset mid-run clears a nonzero result with carry
        apply(4'd0, 8'hFF, 8'h02);
        @(negedge clk);
        check_out("R3 carry before reset", 8'h01, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid-run reset", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R2 after reset release", 8'h01, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule